// File: doc/BRIEF.md
# Snooping Bus Coherence Controller

This block keeps the coherence state of a small direct-mapped private write-back cache that sits on a shared snooping bus. Each line is Invalid, Shared (read-only) or Exclusive (read/write) and carries a stored tag. A CPU request is answered as a hit with no bus traffic, or as a miss that raises bus transactions through a request/grant handshake and then fills the line. Snooped read misses and write misses from other caches downgrade or invalidate matching lines. When the snooped line is held Exclusive, the block supplies the dirty block and raises an abort so that memory does not answer.

Writes to a line that is not Exclusive always go out as a full write miss; there is no upgrade transaction. An address splits into a low index field of `IDX_W` bits and a tag made of the remaining upper bits.

The request sequencer has four states:

| State | What happens | Leaves to |
| --- | --- | --- |
| `S_IDLE` | Waits for a CPU request and looks it up. | `S_RESP` on a hit, `S_WB` on a miss that replaces an Exclusive line, `S_MISS` on any other miss. |
| `S_WB` | Writes the victim line back over the bus. | `S_MISS` once the write-back is granted, or at once if a snoop has already taken the victim out of Exclusive. |
| `S_MISS` | Places the read miss or write miss on the bus and fills the line. | `S_RESP` on grant. |
| `S_RESP` | Pulses the response to the CPU. | `S_IDLE`. |

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `bus_req`, `cpu_resp_valid` and `mem_abort` are 0, so the first access to any address is a miss.
- R2: A CPU read to a line that misses issues bus command 1 (read miss) with the request address and leaves the line Shared. The response (`cpu_resp_hit`=0) follows 2 cycles after acceptance when the grant is already high.
- R3: A CPU write to a line that is Invalid, or Shared with a matching tag, issues bus command 2 (write miss) with the request address and leaves the line Exclusive.
- R4: A read to a Shared or Exclusive line with a matching tag, and a write to an Exclusive line with a matching tag, respond with `cpu_resp_hit`=1 one cycle after acceptance and raise no bus request.
- R5: A snooped read miss (`snp_cmd`=0) that matches an Exclusive line pulses `mem_abort` one cycle later and moves the line to Shared.
- R6: A snooped write miss (`snp_cmd`=1) that matches a line moves it to Invalid. If the line was Exclusive, `mem_abort` pulses one cycle later; if it was Shared, `mem_abort` stays 0.
- R7: A miss whose index holds an Exclusive line with another tag first issues bus command 3 (write-back) carrying the victim address, then the miss command, and responds 3 cycles after acceptance. A Shared victim is dropped without a write-back.
- R8: A transaction is taken in a cycle where `bus_req` and `bus_gnt` are both 1. Until then, `bus_req` stays high with a stable command and address, and no response is given.
- R9: In any cycle with `snp_valid`=1, the snoop takes priority. `bus_req` is 0 and no new CPU request is accepted; the pending work resumes in the next cycle without the snoop.
- R10: The stored tag is compared only for a valid line. A tag mismatch is a miss, and a snoop whose tag mismatches changes nothing and does not raise `mem_abort`.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU request, held until the response |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | CPU line address |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_hit | output | 1 | 1 if the request was a hit |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Address of the bus transaction |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 1 | 0 read miss, 1 write miss |
| snp_addr | input | ADDR_W | Snooped line address |
| mem_abort | output | 1 | Owner supplies the block; memory access aborted |

## Verification
A hit response is due in the first cycle after the acceptance edge. A plain miss responds in the second cycle, with its bus command visible in the first. A miss with a write-back responds in the third, after two recorded bus transactions. `mem_abort` is due one cycle after the snoop edge. The bench drives inputs on the falling edge and samples on the falling edge after each rising edge. It counts the cycles from acceptance to the response and records every granted transaction in order, then compares them with the counts and sequences above. It samples line states only indirectly, through hit/miss results and bus commands of follow-up accesses made after each snoop.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        L_INV = 2'd0,
        L_SHR = 2'd1,
        L_EXC = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WBACK  = 2'd3
    } bus_cmd_t;

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
    import coh_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output line_st_t         rd_state,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  line_st_t         fill_st,
    input  logic             snp_valid,
    input  logic             snp_is_wm,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [TAG_W-1:0] snp_tag,
    output logic             mem_abort
);
    localparam int LINES = 1 << IDX_W;

    line_st_t         st_arr  [LINES];
    logic [TAG_W-1:0] tag_arr [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        line_st_t         st_q;
        logic [TAG_W-1:0] tag_q;
        logic             snp_match;

        assign snp_match = snp_valid && (snp_idx == IDX_W'(i)) &&
                           (st_q != L_INV) && (tag_q == snp_tag);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q  <= L_INV;
                tag_q <= '0;
            end else if (fill_en && (fill_idx == IDX_W'(i))) begin
                st_q  <= fill_st;
                tag_q <= fill_tag;
            end else if (snp_match) begin
                unique case (st_q)
                    L_SHR:   if (snp_is_wm) st_q <= L_INV;
                    L_EXC:   st_q <= snp_is_wm ? L_INV : L_SHR;
                    default: st_q <= st_q;
                endcase
            end
        end

        assign st_arr[i]  = st_q;
        assign tag_arr[i] = tag_q;
    end

    assign rd_state = st_arr[rd_idx];
    assign rd_tag   = tag_arr[rd_idx];

    logic snp_owner;
    assign snp_owner = snp_valid && (st_arr[snp_idx] == L_EXC) &&
                       (tag_arr[snp_idx] == snp_tag);

    always_ff @(posedge clk) begin
        if (!rst_n) mem_abort <= 1'b0;
        else        mem_abort <= snp_owner;
    end

    assert_abort_needs_snoop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_abort |-> $past(snp_valid));

    assert_no_fill_in_snoop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> !snp_valid);

endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
    import coh_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req_valid,
    input  logic                    cpu_req_write,
    input  logic [ADDR_W-1:0]       cpu_req_addr,
    output logic                    cpu_resp_valid,
    output logic                    cpu_resp_hit,
    input  logic                    snp_valid,
    input  logic                    bus_gnt,
    output logic                    bus_req,
    output bus_cmd_t                bus_cmd,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [IDX_W-1:0]        lk_idx,
    input  line_st_t                lk_state,
    input  logic [ADDR_W-IDX_W-1:0] lk_tag,
    output logic                    fill_en,
    output logic [IDX_W-1:0]        fill_idx,
    output logic [ADDR_W-IDX_W-1:0] fill_tag,
    output line_st_t                fill_st
);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef enum logic [1:0] {S_IDLE, S_WB, S_MISS, S_RESP} seq_st_t;

    seq_st_t           state, nxt;
    logic [ADDR_W-1:0] q_addr;
    logic              q_write;
    logic              hit_q;

    logic [IDX_W-1:0]  cpu_idx, q_idx;
    logic [TAG_W-1:0]  cpu_tag, q_tag, lk_addr_tag;
    logic              tag_hit, accept, req_hit, take;

    assign cpu_idx     = cpu_req_addr[IDX_W-1:0];
    assign cpu_tag     = cpu_req_addr[ADDR_W-1:IDX_W];
    assign q_idx       = q_addr[IDX_W-1:0];
    assign q_tag       = q_addr[ADDR_W-1:IDX_W];
    assign lk_idx      = (state == S_IDLE) ? cpu_idx : q_idx;
    assign lk_addr_tag = (state == S_IDLE) ? cpu_tag : q_tag;
    assign tag_hit     = (lk_state != L_INV) && (lk_tag == lk_addr_tag);
    assign accept      = cpu_req_valid && !snp_valid;
    assign req_hit     = tag_hit && (!cpu_req_write || (lk_state == L_EXC));
    assign take        = bus_req && bus_gnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            q_addr  <= '0;
            q_write <= 1'b0;
            hit_q   <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && accept) begin
                q_addr  <= cpu_req_addr;
                q_write <= cpu_req_write;
                hit_q   <= req_hit;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (accept) begin
                    if (req_hit)                 nxt = S_RESP;
                    else if (lk_state == L_EXC)  nxt = S_WB;
                    else                         nxt = S_MISS;
                end
            end
            S_WB: begin
                if (lk_state != L_EXC || take) nxt = S_MISS;
            end
            S_MISS: begin
                if (take) nxt = S_RESP;
            end
            S_RESP: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        bus_req        = 1'b0;
        bus_cmd        = BC_NONE;
        bus_addr       = '0;
        fill_en        = 1'b0;
        fill_idx       = q_idx;
        fill_tag       = q_tag;
        fill_st        = L_INV;
        cpu_resp_valid = 1'b0;
        cpu_resp_hit   = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_WB: begin
                bus_req  = !snp_valid && (lk_state == L_EXC);
                bus_cmd  = BC_WBACK;
                bus_addr = {lk_tag, q_idx};
                fill_en  = take;
                fill_tag = lk_tag;
                fill_st  = L_INV;
            end
            S_MISS: begin
                bus_req  = !snp_valid;
                bus_cmd  = q_write ? BC_WRMISS : BC_RDMISS;
                bus_addr = q_addr;
                fill_en  = take;
                fill_tag = q_tag;
                fill_st  = q_write ? L_EXC : L_SHR;
            end
            S_RESP: begin
                cpu_resp_valid = 1'b1;
                cpu_resp_hit   = hit_q;
            end
            default: ;
        endcase
    end

    assert_resp_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_valid |=> !cpu_resp_valid);

    assert_hit_next_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && accept && req_hit) |=> (cpu_resp_valid && cpu_resp_hit));

    assert_wb_then_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WB && take) |=> (state == S_MISS));

    assert_miss_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MISS && !take) |=> (state == S_MISS && $stable(bus_addr) && !cpu_resp_valid));

endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_resp_valid,
    output logic              cpu_resp_hit,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              snp_valid,
    input  logic              snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              mem_abort
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] lk_idx, fill_idx;
    logic [TAG_W-1:0] lk_tag, fill_tag;
    line_st_t         lk_state, fill_st;
    logic             fill_en;
    bus_cmd_t         cmd_e;

    coh_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_req_valid  (cpu_req_valid),
        .cpu_req_write  (cpu_req_write),
        .cpu_req_addr   (cpu_req_addr),
        .cpu_resp_valid (cpu_resp_valid),
        .cpu_resp_hit   (cpu_resp_hit),
        .snp_valid      (snp_valid),
        .bus_gnt        (bus_gnt),
        .bus_req        (bus_req),
        .bus_cmd        (cmd_e),
        .bus_addr       (bus_addr),
        .lk_idx         (lk_idx),
        .lk_state       (lk_state),
        .lk_tag         (lk_tag),
        .fill_en        (fill_en),
        .fill_idx       (fill_idx),
        .fill_tag       (fill_tag),
        .fill_st        (fill_st)
    );

    coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (lk_idx),
        .rd_state  (lk_state),
        .rd_tag    (lk_tag),
        .fill_en   (fill_en),
        .fill_idx  (fill_idx),
        .fill_tag  (fill_tag),
        .fill_st   (fill_st),
        .snp_valid (snp_valid),
        .snp_is_wm (snp_cmd),
        .snp_idx   (snp_addr[IDX_W-1:0]),
        .snp_tag   (snp_addr[ADDR_W-1:IDX_W]),
        .mem_abort (mem_abort)
    );

    assign bus_cmd = cmd_e;

endmodule

// File: tb/snoop_coh_ctrl_tb_top.sv
module snoop_coh_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_write = 1'b0;
    logic [15:0] cpu_req_addr = '0;
    logic        cpu_resp_valid, cpu_resp_hit;
    logic        bus_req;
    logic        bus_gnt = 1'b1;
    logic [1:0]  bus_cmd;
    logic [15:0] bus_addr;
    logic        snp_valid = 1'b0;
    logic        snp_cmd = 1'b0;
    logic [15:0] snp_addr = '0;
    logic        mem_abort;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    localparam logic [15:0] A_ADDR = 16'h0012;
    localparam logic [15:0] B_ADDR = 16'h0022;
    localparam logic [15:0] C_ADDR = 16'h0035;
    localparam logic [15:0] D_ADDR = 16'h0047;

    always #2.5 clk = ~clk;

    snoop_coh_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_resp_valid(cpu_resp_valid),
        .cpu_resp_hit(cpu_resp_hit), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_cmd(bus_cmd), .bus_addr(bus_addr), .snp_valid(snp_valid),
        .snp_cmd(snp_cmd), .snp_addr(snp_addr), .mem_abort(mem_abort)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    // One CPU access with grant high; records granted bus transactions in order.
    task automatic cpu_op(input logic wr, input logic [15:0] a, input logic exp_hit,
                          input int exp_cyc, input logic [1:0] c0, input logic [15:0] a0,
                          input logic [1:0] c1, input logic [15:0] a1, input string req);
        logic [1:0]  rc [2];
        logic [15:0] ra [2];
        int nops = 0;
        int cyc  = 0;
        int exp_ops;
        exp_ops = exp_hit ? 0 : ((c1 == 2'd0) ? 1 : 2);
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_addr  = a;
        @(posedge clk);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            cyc++;
            if (bus_req && bus_gnt) begin
                if (nops < 2) begin
                    rc[nops] = bus_cmd;
                    ra[nops] = bus_addr;
                end
                nops++;
            end
            if (cpu_resp_valid) break;
        end
        check(cpu_resp_valid === 1'b1, {req, " response"}, int'(cpu_resp_valid), 1);
        check(cpu_resp_hit === exp_hit, {req, " hit flag"}, int'(cpu_resp_hit), int'(exp_hit));
        check(cyc == exp_cyc, {req, " latency"}, cyc, exp_cyc);
        check(nops == exp_ops, {req, " bus op count"}, nops, exp_ops);
        if (exp_ops >= 1 && nops >= 1)
            check(rc[0] == c0 && ra[0] == a0, {req, " first bus op"},
                  int'({rc[0], ra[0]}), int'({c0, a0}));
        if (exp_ops == 2 && nops >= 2)
            check(rc[1] == c1 && ra[1] == a1, {req, " second bus op"},
                  int'({rc[1], ra[1]}), int'({c1, a1}));
        cpu_req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic snoop(input logic wm, input logic [15:0] a, input logic exp_abort,
                         input string req);
        snp_valid = 1'b1;
        snp_cmd   = wm;
        snp_addr  = a;
        #1;
        check(bus_req === 1'b0, {req, " bus quiet during snoop"}, int'(bus_req), 0);
        @(posedge clk);
        @(negedge clk);
        check(mem_abort === exp_abort, {req, " mem_abort"}, int'(mem_abort), int'(exp_abort));
        snp_valid = 1'b0;
        @(negedge clk);
        check(mem_abort === 1'b0, {req, " mem_abort one pulse"}, int'(mem_abort), 0);
    endtask

    task automatic t_reset();
        check(bus_req === 1'b0, "R1 bus_req after reset", int'(bus_req), 0);
        check(cpu_resp_valid === 1'b0, "R1 resp after reset", int'(cpu_resp_valid), 0);
        check(mem_abort === 1'b0, "R1 abort after reset", int'(mem_abort), 0);
        cpu_op(1'b0, A_ADDR, 1'b0, 2, 2'd1, A_ADDR, 2'd0, 16'h0, "R1 R2 first read miss");
    endtask

    task automatic t_hits_and_write_miss();
        cpu_op(1'b0, A_ADDR, 1'b1, 1, 2'd0, 16'h0, 2'd0, 16'h0, "R4 read hit shared");
        cpu_op(1'b1, A_ADDR, 1'b0, 2, 2'd2, A_ADDR, 2'd0, 16'h0, "R3 write to shared");
        cpu_op(1'b1, A_ADDR, 1'b1, 1, 2'd0, 16'h0, 2'd0, 16'h0, "R4 write hit exclusive");
        cpu_op(1'b0, A_ADDR, 1'b1, 1, 2'd0, 16'h0, 2'd0, 16'h0, "R4 read hit exclusive");
        cpu_op(1'b1, C_ADDR, 1'b0, 2, 2'd2, C_ADDR, 2'd0, 16'h0, "R3 write to invalid");
    endtask

    task automatic t_snoop_mismatch();
        snoop(1'b0, B_ADDR, 1'b0, "R10 snoop tag mismatch");
        cpu_op(1'b1, A_ADDR, 1'b1, 1, 2'd0, 16'h0, 2'd0, 16'h0, "R10 line kept exclusive");
    endtask

    task automatic t_snoop_read_owner();
        snoop(1'b0, A_ADDR, 1'b1, "R5 snoop read on owner");
        cpu_op(1'b0, A_ADDR, 1'b1, 1, 2'd0, 16'h0, 2'd0, 16'h0, "R5 line still readable");
        cpu_op(1'b1, A_ADDR, 1'b0, 2, 2'd2, A_ADDR, 2'd0, 16'h0, "R5 line now shared");
    endtask

    task automatic t_snoop_write();
        snoop(1'b1, A_ADDR, 1'b1, "R6 snoop write on owner");
        cpu_op(1'b0, A_ADDR, 1'b0, 2, 2'd1, A_ADDR, 2'd0, 16'h0, "R6 owner invalidated");
        snoop(1'b1, A_ADDR, 1'b0, "R6 snoop write on shared");
        cpu_op(1'b0, A_ADDR, 1'b0, 2, 2'd1, A_ADDR, 2'd0, 16'h0, "R6 shared invalidated");
    endtask

    task automatic t_replace();
        cpu_op(1'b1, A_ADDR, 1'b0, 2, 2'd2, A_ADDR, 2'd0, 16'h0, "R3 write miss for victim");
        cpu_op(1'b0, B_ADDR, 1'b0, 3, 2'd3, A_ADDR, 2'd1, B_ADDR, "R7 dirty victim written back");
        cpu_op(1'b0, B_ADDR, 1'b1, 1, 2'd0, 16'h0, 2'd0, 16'h0, "R7 new line present");
        cpu_op(1'b0, A_ADDR, 1'b0, 2, 2'd1, A_ADDR, 2'd0, 16'h0, "R7 shared victim silent");
    endtask

    task automatic t_handshake();
        bus_gnt       = 1'b0;
        cpu_req_valid = 1'b1;
        cpu_req_write = 1'b0;
        cpu_req_addr  = C_ADDR ^ 16'h0100;
        @(posedge clk);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(bus_req === 1'b1, "R8 request held", int'(bus_req), 1);
            check(bus_cmd == 2'd3 && bus_addr == C_ADDR, "R8 write-back held stable",
                  int'({bus_cmd, bus_addr}), int'({2'd3, C_ADDR}));
            check(cpu_resp_valid === 1'b0, "R8 no response without grant", int'(cpu_resp_valid), 0);
        end
        bus_gnt = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(bus_cmd == 2'd1 && bus_addr == (C_ADDR ^ 16'h0100), "R8 miss after grant",
              int'({bus_cmd, bus_addr}), int'({2'd1, C_ADDR ^ 16'h0100}));
        @(posedge clk);
        @(negedge clk);
        check(cpu_resp_valid === 1'b1 && cpu_resp_hit === 1'b0, "R8 response after grant",
              int'({cpu_resp_valid, cpu_resp_hit}), 2);
        cpu_req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_priority();
        cpu_req_valid = 1'b1;
        cpu_req_write = 1'b0;
        cpu_req_addr  = D_ADDR;
        snp_valid     = 1'b1;
        snp_cmd       = 1'b0;
        snp_addr      = 16'h0100;
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        check(bus_req === 1'b0, "R9 request not accepted during snoop", int'(bus_req), 0);
        @(posedge clk);
        @(negedge clk);
        check(bus_req === 1'b1 && bus_cmd == 2'd1, "R9 miss after snoop",
              int'({bus_req, bus_cmd}), int'({1'b1, 2'd1}));
        snp_valid = 1'b1;
        #1;
        check(bus_req === 1'b0, "R9 bus request dropped for snoop", int'(bus_req), 0);
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0;
        check(cpu_resp_valid === 1'b0, "R9 no grant taken during snoop", int'(cpu_resp_valid), 0);
        #1;
        check(bus_req === 1'b1, "R9 request resumes", int'(bus_req), 1);
        @(posedge clk);
        @(negedge clk);
        check(cpu_resp_valid === 1'b1 && cpu_resp_hit === 1'b0, "R9 response after resume",
              int'({cpu_resp_valid, cpu_resp_hit}), 2);
        cpu_req_valid = 1'b0;
        @(negedge clk);
        cpu_op(1'b0, D_ADDR, 1'b1, 1, 2'd0, 16'h0, 2'd0, 16'h0, "R9 line filled");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hits_and_write_miss();
        t_snoop_mismatch();
        t_snoop_read_owner();
        t_snoop_write();
        t_replace();
        t_handshake();
        t_priority();
        finish_run();
    end

endmodule